// File: doc/BRIEF.md
# Receive Filter and Ring Buffer Writer

This block sits between an Ethernet receive byte stream and the packet memory of a network controller. For each incoming frame it decides from three acceptance controls and the 6-byte station address whether the frame is kept. A kept frame is stored in a circular receive area made of 256-byte pages, bounded by a first page and a stop page. Each stored frame starts on a page boundary with a 4-byte header: status, next page, and stored length. The payload follows the header and wraps from the stop page back to the first page.

Payload bytes are written at once as they arrive, beginning at offset 4 of the current page. When the last byte has arrived, short frames are padded with zeros to the minimum size. The header is then written at offsets 0 to 3 of the starting page, because only then are the length and the next page known. On completion the block raises a one-cycle strobe carrying the new current page, which the surrounding register file loads, together with the receive interrupt strobe.

The controller's state machine has the states ST_IDLE (wait for the first byte, apply the halt and space gates), ST_TAKE (store bytes, check the address after the sixth byte), ST_SKIP (swallow the rest of a refused frame), ST_PAD (write zero padding), ST_HEAD (write the four header bytes) and ST_DONE (strobe the update). The transitions are:
- IDLE→SKIP when a gated first byte is not the last.
- IDLE→TAKE when an accepted first byte is not the last.
- IDLE→PAD when a single-byte frame is taken promiscuously.
- TAKE→SKIP when the address test fails at byte six.
- TAKE→IDLE when a short or refused frame ends.
- TAKE→PAD when a frame ends below 60 bytes.
- TAKE→HEAD when a frame ends at 60 bytes or more.
- SKIP→IDLE on the last byte.
- PAD→HEAD when the length reaches 60.
- HEAD→DONE after header byte 3.
- DONE→IDLE.

Top module: `rxw_ring_writer`

## Requirements
- R1: With `take_all` high, every frame that passes the halt and space gates is stored, including frames shorter than 6 bytes.
- R2: Without `take_all`, a destination of six 0xFF bytes is stored only when `take_bcast` is high.
- R3: Without `take_all`, a destination that is not all-ones and whose first byte has bit 0 set is stored only when `take_mcast` is high.
- R4: Without `take_all`, any other destination is stored only if all six bytes equal `station_mac`, whose first received byte is bits 47:40. A frame of fewer than 6 bytes is refused. A refused frame writes at most its first 6 bytes, at the payload addresses, and produces no header, no pointer update and no interrupt.
- R5: If `halt` is high when the first byte of a frame is accepted, the whole frame is consumed with no memory write.
- R6: The free space is (bnd-cur) pages if cur<bnd, and otherwise (stop-first)-(cur-bnd) pages. When the free space times 256 is below MAX_FRM+4 (1518 by default), the frame is consumed with no memory write.
- R7: A stored frame shorter than 60 bytes is followed by zero bytes up to 60, and `s_ready` is low while they are written.
- R8: After the payload, the header is written at byte offsets 0,1,2,3 of the starting page, in this order: status, next page, (L+4) low byte, (L+4) high byte. Here L is the padded length.
- R9: The next page is start + ceil((L+8)/256). If this is at or past the stop page, (stop-first) is subtracted from it.
- R10: Payload bytes go to consecutive addresses from start*256+4. An address that reaches stop*256 continues at first*256.
- R11: The status byte `rx_status` is 0x01, or 0x21 when the first destination byte has bit 0 set. It is updated for stored frames only.
- R12: The cycle after the last header write, `rx_irq` and `cur_pg_upd` are high together for exactly one cycle, with `cur_pg_new` holding the next page. `s_ready` is low during the header and that cycle.
- R13: After reset, `s_ready` is high, and `mem_we`, `rx_irq`, `cur_pg_upd` are low and `rx_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_all | input | 1 | Accept every frame |
| take_bcast | input | 1 | Accept all-ones destination |
| take_mcast | input | 1 | Accept group destination |
| station_mac | input | 48 | Own station address, first byte in bits 47:40 |
| ring_first_pg | input | PG_W | First page of the receive ring |
| ring_stop_pg | input | PG_W | Page just past the ring |
| bnd_pg | input | PG_W | Oldest page not yet read by software |
| cur_pg | input | PG_W | Page where the next frame starts |
| halt | input | 1 | Device stopped: discard frames |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_ready | output | 1 | Block accepts a stream byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg_upd | output | 1 | Load strobe for the current page |
| cur_pg_new | output | PG_W | New current page |
| rx_status | output | 8 | Status of the last stored frame |
| rx_irq | output | 1 | Receive interrupt strobe |

## Verification
On every cycle the assertions check these rules:
- the interrupt and the page update come as a single pulse;
- a header write always precedes that pulse;
- every write lands inside the ring;
- the new page lies inside the ring;
- a halted first byte writes nothing;
- the stream stalls only when padding or header writes begin.

Only the bench scenarios can show the byte-exact content and order of the writes. These include the address wrap at the stop page, the rounding of the next page at the 248/249-byte boundary, the free-space threshold one page either side, and the verdict of each address class under each acceptance setting.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE,
        ST_SKIP,
        ST_PAD,
        ST_HEAD,
        ST_DONE
    } rxw_state_e;

    // status byte bits written to the frame header
    localparam logic [7:0] STAT_OK  = 8'h01;
    localparam logic [7:0] STAT_GRP = 8'h20;

endpackage

// File: rtl/rxw_addr_filter.sv
module rxw_addr_filter #(
    parameter int MAC_N = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_en,
    input  logic               first,
    input  logic [2:0]         idx,
    input  logic [7:0]         byte_in,
    input  logic [8*MAC_N-1:0] station,
    input  logic               take_all,
    input  logic               take_bcast,
    input  logic               take_mcast,
    output logic               accept,
    output logic               grp_bit
);

    logic       bc_q, uc_q, grp_q;
    logic [7:0] stn_byte;
    logic       eff_bc, eff_uc, eff_grp;

    // pick the station byte that lines up with the current position
    always_comb begin
        stn_byte = 8'h00;
        for (int i = 0; i < MAC_N; i++) begin
            if (idx == 3'(i)) stn_byte = station[8*(MAC_N-1-i) +: 8];
        end
    end

    assign eff_bc  = (first | bc_q) & (byte_in == 8'hFF);
    assign eff_uc  = (first | uc_q) & (byte_in == stn_byte);
    assign eff_grp = first ? byte_in[0] : grp_q;

    // broadcast is tested before the group bit, which it also carries
    assign accept  = take_all | (eff_bc ? take_bcast : (eff_grp ? take_mcast : eff_uc));
    assign grp_bit = grp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q  <= 1'b0;
            uc_q  <= 1'b0;
            grp_q <= 1'b0;
        end else if (byte_en) begin
            bc_q  <= eff_bc;
            uc_q  <= eff_uc;
            grp_q <= eff_grp;
        end
    end

endmodule

// File: rtl/rxw_space_check.sv
module rxw_space_check #(
    parameter int PG_W  = 8,
    parameter int NEED  = 1518
) (
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            room_ok
);

    localparam int SW = PG_W + 10;

    logic signed [SW-1:0] span_pg, free_pg, free_bytes;

    always_comb begin
        span_pg = SW'(stop_pg) - SW'(first_pg);
        if (cur_pg < bnd_pg) free_pg = SW'(bnd_pg) - SW'(cur_pg);
        else                 free_pg = span_pg - (SW'(cur_pg) - SW'(bnd_pg));
        free_bytes = free_pg <<< 8;
        room_ok    = (free_bytes >= $signed(SW'(NEED)));
    end

endmodule

// File: rtl/rxw_page_calc.sv
module rxw_page_calc #(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [PG_W-1:0]  first_pg,
    input  logic [PG_W-1:0]  stop_pg,
    output logic [PG_W-1:0]  next_pg
);

    localparam int CW = (PG_W > LEN_W ? PG_W : LEN_W) + 2;

    logic [CW-1:0] used_pg, raw_pg;

    always_comb begin
        // header plus trailing check space, rounded up to whole pages
        used_pg = (CW'(frm_len) + CW'(8) + CW'(255)) >> 8;
        raw_pg  = CW'(base_pg) + used_pg;
        if (raw_pg >= CW'(stop_pg)) raw_pg = raw_pg - (CW'(stop_pg) - CW'(first_pg));
        next_pg = raw_pg[PG_W-1:0];
    end

endmodule

// File: rtl/rxw_ring_writer.sv
module rxw_ring_writer
    import rxw_pkg::*;
#(
    parameter int PG_W    = 8,
    parameter int MAX_FRM = 1514,
    parameter int MIN_FRM = 60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_all,
    input  logic            take_bcast,
    input  logic            take_mcast,
    input  logic [47:0]     station_mac,
    input  logic [PG_W-1:0] ring_first_pg,
    input  logic [PG_W-1:0] ring_stop_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    input  logic            halt,
    input  logic            s_valid,
    input  logic [7:0]      s_data,
    input  logic            s_last,
    output logic            s_ready,
    output logic            mem_we,
    output logic [PG_W+7:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            cur_pg_upd,
    output logic [PG_W-1:0] cur_pg_new,
    output logic [7:0]      rx_status,
    output logic            rx_irq
);

    localparam int ADDR_W = PG_W + 8;
    localparam int LEN_W  = 16;
    localparam int HDR_N  = 4;
    localparam int MAC_N  = 6;
    localparam int NEED   = MAX_FRM + HDR_N;

    rxw_state_e state_q, state_d;

    logic [LEN_W-1:0]  len_q, len_inc, len_hdr;
    logic [ADDR_W-1:0] wr_addr_q, first_addr;
    logic [PG_W-1:0]   base_pg_q, nxt_pg;
    logic [1:0]        hdr_idx_q;
    logic [7:0]        status_q;
    logic              beat, room_ok, gated;
    logic              flt_en, flt_first, flt_accept, flt_grp;
    logic [2:0]        flt_idx;
    logic              in_idle;

    function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] a,
                                                    input logic [PG_W-1:0]   f_pg,
                                                    input logic [PG_W-1:0]   s_pg);
        logic [ADDR_W-1:0] n;
        n = a + ADDR_W'(1);
        if (n == {s_pg, 8'h00}) n = {f_pg, 8'h00};
        return n;
    endfunction

    assign beat       = s_valid & s_ready;
    assign gated      = halt | ~room_ok;
    assign len_inc    = len_q + LEN_W'(1);
    assign len_hdr    = len_q + LEN_W'(HDR_N);
    assign first_addr = {cur_pg, 8'(HDR_N)};
    assign in_idle    = (state_q == ST_IDLE);

    assign flt_first = in_idle;
    assign flt_idx   = in_idle ? 3'd0 : len_q[2:0];
    assign flt_en    = beat & ((in_idle & ~gated) |
                               ((state_q == ST_TAKE) && (len_q < LEN_W'(MAC_N))));

    rxw_addr_filter #(.MAC_N(MAC_N)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (flt_en),
        .first      (flt_first),
        .idx        (flt_idx),
        .byte_in    (s_data),
        .station    (station_mac),
        .take_all   (take_all),
        .take_bcast (take_bcast),
        .take_mcast (take_mcast),
        .accept     (flt_accept),
        .grp_bit    (flt_grp)
    );

    rxw_space_check #(.PG_W(PG_W), .NEED(NEED)) u_space (
        .first_pg (ring_first_pg),
        .stop_pg  (ring_stop_pg),
        .bnd_pg   (bnd_pg),
        .cur_pg   (cur_pg),
        .room_ok  (room_ok)
    );

    rxw_page_calc #(.PG_W(PG_W), .LEN_W(LEN_W)) u_pages (
        .base_pg  (base_pg_q),
        .frm_len  (len_q),
        .first_pg (ring_first_pg),
        .stop_pg  (ring_stop_pg),
        .next_pg  (nxt_pg)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (beat) begin
                    if (gated)         state_d = s_last ? ST_IDLE : ST_SKIP;
                    else if (!s_last)  state_d = ST_TAKE;
                    else if (take_all) state_d = ST_PAD;
                    else               state_d = ST_IDLE;
                end
            end
            ST_TAKE: begin
                if (beat) begin
                    if ((len_q == LEN_W'(MAC_N - 1)) && !flt_accept)
                        state_d = s_last ? ST_IDLE : ST_SKIP;
                    else if (s_last) begin
                        if ((len_inc < LEN_W'(MAC_N)) && !take_all) state_d = ST_IDLE;
                        else if (len_inc < LEN_W'(MIN_FRM))         state_d = ST_PAD;
                        else                                        state_d = ST_HEAD;
                    end
                end
            end
            ST_SKIP: begin
                if (beat && s_last) state_d = ST_IDLE;
            end
            ST_PAD: begin
                if (len_q == LEN_W'(MIN_FRM - 1)) state_d = ST_HEAD;
            end
            ST_HEAD: begin
                if (hdr_idx_q == 2'd3) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            wr_addr_q <= '0;
            base_pg_q <= '0;
            hdr_idx_q <= '0;
            status_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (beat && !gated) begin
                        len_q     <= LEN_W'(1);
                        base_pg_q <= cur_pg;
                        wr_addr_q <= ring_step(first_addr, ring_first_pg, ring_stop_pg);
                    end
                end
                ST_TAKE: begin
                    if (beat) begin
                        len_q     <= len_inc;
                        wr_addr_q <= ring_step(wr_addr_q, ring_first_pg, ring_stop_pg);
                    end
                end
                ST_PAD: begin
                    len_q     <= len_inc;
                    wr_addr_q <= ring_step(wr_addr_q, ring_first_pg, ring_stop_pg);
                end
                ST_HEAD: hdr_idx_q <= hdr_idx_q + 2'd1;
                default: ;
            endcase
            if ((state_d == ST_HEAD) && (state_q != ST_HEAD)) begin
                hdr_idx_q <= 2'd0;
                status_q  <= STAT_OK | (flt_grp ? STAT_GRP : 8'h00);
            end
            // the group bit of a one-byte frame is registered in the same beat
            if (in_idle && (state_d == ST_PAD)) begin
                status_q <= STAT_OK | (s_data[0] ? STAT_GRP : 8'h00);
            end
        end
    end

    // outputs
    always_comb begin
        s_ready    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = wr_addr_q;
        mem_wdata  = 8'h00;
        cur_pg_upd = 1'b0;
        rx_irq     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                s_ready   = 1'b1;
                mem_we    = beat & ~gated;
                mem_addr  = first_addr;
                mem_wdata = s_data;
            end
            ST_TAKE: begin
                s_ready   = 1'b1;
                mem_we    = beat;
                mem_wdata = s_data;
            end
            ST_SKIP: s_ready = 1'b1;
            ST_PAD:  mem_we  = 1'b1;
            ST_HEAD: begin
                mem_we   = 1'b1;
                mem_addr = {base_pg_q, 6'd0, hdr_idx_q};
                unique case (hdr_idx_q)
                    2'd0: mem_wdata = status_q;
                    2'd1: mem_wdata = 8'(nxt_pg);
                    2'd2: mem_wdata = len_hdr[7:0];
                    2'd3: mem_wdata = len_hdr[15:8];
                    default: mem_wdata = 8'h00;
                endcase
            end
            ST_DONE: begin
                cur_pg_upd = 1'b1;
                rx_irq     = 1'b1;
            end
            default: ;
        endcase
    end

    assign cur_pg_new = nxt_pg;
    assign rx_status  = status_q;

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int PG_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_idle,
    input logic            halt,
    input logic            s_valid,
    input logic            s_ready,
    input logic            mem_we,
    input logic [PG_W+7:0] mem_addr,
    input logic [PG_W-1:0] ring_first_pg,
    input logic [PG_W-1:0] ring_stop_pg,
    input logic            cur_pg_upd,
    input logic [PG_W-1:0] cur_pg_new,
    input logic            rx_irq
);

    assert_irq_with_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> cur_pg_upd);

    assert_irq_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    assert_header_before_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ($past(mem_we) && !$past(s_ready)));

    assert_stall_only_to_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_ready) |-> mem_we);

    assert_halt_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && s_valid && halt) |-> !mem_we);

    assert_write_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr >= {ring_first_pg, 8'h00}) && (mem_addr < {ring_stop_pg, 8'h00})));

    assert_next_in_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_pg_upd |-> ((cur_pg_new >= ring_first_pg) && (cur_pg_new < ring_stop_pg)));

endmodule

bind rxw_ring_writer rxw_checker #(.PG_W(PG_W)) u_rxw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_idle       (in_idle),
    .halt          (halt),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .ring_first_pg (ring_first_pg),
    .ring_stop_pg  (ring_stop_pg),
    .cur_pg_upd    (cur_pg_upd),
    .cur_pg_new    (cur_pg_new),
    .rx_irq        (rx_irq)
);

// File: tb/tb_rxw_ring_writer.sv
`timescale 1ns/1ps
module tb_rxw_ring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_all = 0, take_bcast = 0, take_mcast = 0;
    logic [47:0] station_mac = 48'h02_11_22_33_44_55;
    logic [7:0]  ring_first_pg = 8'h40, ring_stop_pg = 8'h60;
    logic [7:0]  bnd_pg = 8'h40, cur_pg_r;
    logic        halt = 0;
    logic        s_valid = 0, s_last = 0;
    logic [7:0]  s_data = 0;
    logic        s_ready, mem_we, cur_pg_upd, rx_irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_pg_new, rx_status;
    logic        ld = 0;
    logic [7:0]  ld_val = 0;

    int total = 0, bad = 0;
    int exp_a[$], exp_d[$], exp_h[$], exp_pg[$], exp_st[$];
    string exp_r[$];

    always #5 clk = ~clk;

    rxw_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .take_all(take_all), .take_bcast(take_bcast),
        .take_mcast(take_mcast), .station_mac(station_mac), .ring_first_pg(ring_first_pg),
        .ring_stop_pg(ring_stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg_r), .halt(halt),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg_upd(cur_pg_upd), .cur_pg_new(cur_pg_new), .rx_status(rx_status), .rx_irq(rx_irq)
    );

    // current page register owned by the surrounding logic
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cur_pg_r <= 8'h40;
        else if (ld)         cur_pg_r <= ld_val;
        else if (cur_pg_upd) cur_pg_r <= cur_pg_new;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the expected event queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_a.size() == 0) chk("R4 unexpected write", int'(mem_addr), -1);
                else begin
                    automatic string r = exp_r.pop_front();
                    automatic int    h = exp_h.pop_front();
                    chk({r, " addr"}, int'(mem_addr), exp_a.pop_front());
                    chk({r, " data"}, int'(mem_wdata), exp_d.pop_front());
                    if (h != 0) chk("R7 ready low while filling", int'(s_ready), 0);
                end
            end
            if (rx_irq) begin
                if (exp_pg.size() == 0) chk("R12 unexpected irq", 1, 0);
                else begin
                    chk("R9 next page", int'(cur_pg_new), exp_pg.pop_front());
                    chk("R11 status", int'(rx_status), exp_st.pop_front());
                    chk("R12 update with irq", int'(cur_pg_upd), 1);
                    chk("R12 ready low at done", int'(s_ready), 0);
                end
            end else if (cur_pg_upd) chk("R12 update without irq", 1, 0);
        end
    end

    function automatic int step(input int a);
        int n = a + 1;
        if (n == int'(ring_stop_pg) * 256) n = int'(ring_first_pg) * 256;
        return n;
    endfunction

    function automatic bit has_room();
        int c = cur_pg_r, b = bnd_pg, f = ring_first_pg, s = ring_stop_pg, fp;
        fp = (c < b) ? (b - c) : ((s - f) - (c - b));
        return (fp * 256) >= 1518;
    endfunction

    task automatic push_w(input int a, input int d, input int h, input string r);
        exp_a.push_back(a); exp_d.push_back(d); exp_h.push_back(h); exp_r.push_back(r);
    endtask

    task automatic send(input logic [7:0] fr[]);
        for (int i = 0; i < fr.size(); i++) begin
            s_valid = 1; s_data = fr[i]; s_last = (i == fr.size() - 1);
            @(negedge clk);
            while (!s_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        s_valid = 0; s_last = 0;
    endtask

    // build a frame, predict every write and the completion, drive it, then drain
    task automatic frame(input logic [47:0] dst, input int n, input string tag);
        logic [7:0] fr[];
        bit acc, bc, grp, uc;
        int base, a, lp, np;
        fr = new[n];
        for (int i = 0; i < n; i++)
            fr[i] = (i < 6) ? dst[8*(5-i) +: 8] : 8'((i * 7 + 3) & 255);
        base = cur_pg_r;
        if (!(halt || !has_room())) begin
            if (n < 6) acc = take_all;
            else begin
                bc = 1; uc = 1;
                for (int i = 0; i < 6; i++) begin
                    bc &= (fr[i] == 8'hFF);
                    uc &= (fr[i] == station_mac[8*(5-i) +: 8]);
                end
                grp = fr[0][0];
                acc = take_all || (bc ? take_bcast : (grp ? take_mcast : uc));
            end
            a = base * 256 + 4;
            if (!acc) begin
                for (int i = 0; i < ((n < 6) ? n : 6); i++) begin
                    push_w(a, fr[i], 0, "R4 refused prefix"); a = step(a);
                end
            end else begin
                for (int i = 0; i < n; i++) begin
                    push_w(a, fr[i], 0, "R10 payload"); a = step(a);
                end
                lp = (n < 60) ? 60 : n;
                for (int i = n; i < lp; i++) begin
                    push_w(a, 0, 1, "R7 padding"); a = step(a);
                end
                np = base + (lp + 8 + 255) / 256;
                if (np >= int'(ring_stop_pg)) np -= (int'(ring_stop_pg) - int'(ring_first_pg));
                push_w(base * 256 + 0, fr[0][0] ? 8'h21 : 8'h01, 1, "R8 header status");
                push_w(base * 256 + 1, np, 1, "R8 header next");
                push_w(base * 256 + 2, (lp + 4) & 255, 1, "R8 header len lo");
                push_w(base * 256 + 3, (lp + 4) >> 8, 1, "R8 header len hi");
                exp_pg.push_back(np);
                exp_st.push_back(fr[0][0] ? 8'h21 : 8'h01);
            end
        end
        send(fr);
        repeat (90) @(posedge clk);
        #1;
        chk({tag, " writes drained"}, exp_a.size(), 0);
        chk({tag, " completion seen"}, exp_pg.size(), 0);
        if (!acc || halt) chk({tag, " page kept"}, int'(cur_pg_r), base);
    endtask

    task automatic set_cur(input logic [7:0] p);
        ld_val = p; ld = 1;
        @(posedge clk); #1;
        ld = 0;
    endtask

    localparam logic [47:0] ME    = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R13 ready after reset", int'(s_ready), 1);
        chk("R13 no write in reset", int'(mem_we), 0);
        chk("R13 irq low in reset", int'(rx_irq), 0);
        chk("R13 status zero in reset", int'(rx_status), 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R13 ready after release", int'(s_ready), 1);
        chk("R13 no update after release", int'(cur_pg_upd), 0);

        frame(ME, 64, "R4 own address");
        frame(OTHER, 64, "R4 last byte differs");
        frame(ME, 4, "R4 short refused");
        frame(BCAST, 70, "R2 broadcast off");
        take_bcast = 1;
        frame(BCAST, 70, "R2 broadcast on");
        frame(MCAST, 80, "R3 group off");
        take_mcast = 1;
        frame(MCAST, 80, "R3 group on");
        take_bcast = 0; take_mcast = 0; take_all = 1;
        frame(OTHER, 100, "R1 promiscuous");
        frame(MCAST, 3, "R1 promiscuous short");
        take_all = 0;
        frame(ME, 20, "R7 padded");
        frame(ME, 60, "R9 exactly minimum");
        frame(ME, 248, "R9 one page edge");
        frame(ME, 249, "R9 two page edge");
        halt = 1;
        frame(ME, 64, "R5 halted");
        halt = 0;
        set_cur(8'h40); bnd_pg = 8'h46;
        frame(ME, 64, "R6 six pages free");
        set_cur(8'h40); bnd_pg = 8'h45;
        frame(ME, 64, "R6 five pages free");
        set_cur(8'h5F); bnd_pg = 8'h50;
        frame(ME, 300, "R10 wrap at stop");
        chk("R9 wrapped page loaded", int'(cur_pg_r), 8'h41);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule